// File: doc/BRIEF.md
# Multi-Write Multi-Read RAM with Last-Writer Table

This block gives several write ports and several read ports on one shared address space, all usable in the same clock cycle. It is made only from simple memories that have one write port and one read port each. Every write port has its own group of banks, with one bank per read port. Each bank in that group receives the port's data, so the write ports never compete for a bank.

A small table built from flip-flops holds one entry per address. Each entry records which write port stored the current value of that address. Because the table is made of registers, all write ports can update it in the same cycle. On a read, the read port looks up the entry for its address and uses it to pick the bank group whose copy it returns. Reads are synchronous. The bank reads and the table lookup are registered in the same cycle, so the data and the select arrive together.

Top module: `lvt_mpram`

## Requirements
- R1: Data written by any write port at address A is returned by any read port that presents A in a later cycle, on `rd_data` one clock after `rd_addr` is sampled.
- R2: A read returns the value from the write port that wrote the address most recently. A later write from another port replaces an earlier one.
- R3: With two write ports, port 0 writing 0x12 and port 1 writing 0x15 in the same cycle leaves both values readable at their own addresses.
- R4: When several write ports write the same address in the same cycle, the highest-numbered port wins, and later reads return its data.
- R5: A read of an address that is being written in the same cycle returns the value held before that write.
- R6: All read ports work independently in the same cycle, on equal or different addresses.
- R7: Reset (`rst` high at a clock edge, active high, synchronous) points every address back to write port 0. After reset, a read returns the last data that port 0 wrote to that address, including data whose write lost a collision. Bank contents are not cleared.
- R8: Each write port and each read port has its own address and data lanes. Lane k of a flat bus occupies bits k*W to k*W+W-1, where W is the lane width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the last-writer table |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write addresses, lane per port |
| wr_data | input | NW*DW | Write data, lane per port |
| rd_addr | input | NR*AW | Read addresses, lane per port |
| rd_data | output | NR*DW | Read data, one cycle after the address |

## Verification
The bench starts with the two-port example at addresses 0x12 and 0x15, which shows whether each port's bank group and table entry are kept apart. It then runs same-address collisions in both orders, which tell a correct highest-port priority from a lowest-port or last-in-code rule. Reads aimed at addresses written in the same cycle show whether the old value or the new value is returned. A reset after mixed writes shows whether the table falls back to port 0 while the banks keep their data. A long random phase with a small address range produces frequent overrides and overlapping reads on both read ports.

// File: rtl/lvt_mpram_pkg.sv
package lvt_mpram_pkg;
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lvt_bank.sv
module lvt_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = lvt_mpram_pkg::sel_width(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*LW-1:0] rd_sel
);
  logic [LW-1:0] tbl [DEPTH];
  logic [AW-1:0] wa [NW];
  logic [NW-1:0] sole_top;
  logic          rst_q;

  always_comb begin
    for (int p = 0; p < NW; p++) wa[p] = wr_addr[p*AW +: AW];
    for (int p = 0; p < NW; p++) begin
      sole_top[p] = wr_en[p];
      for (int q = p + 1; q < NW; q++)
        if (wr_en[q] && wa[q] == wa[p]) sole_top[p] = 1'b0;
    end
  end

  // Ascending loop: the last assignment, the highest port, wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      for (int p = 0; p < NW; p++)
        if (wr_en[p]) tbl[wa[p]] <= LW'(p);
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NR; r++)
      rd_sel[r*LW +: LW] <= tbl[rd_addr[r*AW +: AW]];
  end

  genvar gp;
  generate
    for (gp = 0; gp < NW; gp++) begin : g_chk
      assert_last_writer_R2: assert property (@(posedge clk) disable iff (rst)
        sole_top[gp] |=> tbl[$past(wa[gp])] == LW'(gp))
        else $error("table entry not updated to writer %0d", gp);
    end
    if (NW > 1) begin : g_coll
      assert_collision_top_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en[0] && wr_en[NW-1] && wa[0] == wa[NW-1]) |=> tbl[$past(wa[0])] == LW'(NW-1))
        else $error("collision not won by highest port");
    end
  endgenerate

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst) begin
      for (int i = 0; i < DEPTH; i++)
        assert_reset_clear_R7: assert (tbl[i] == '0)
          else $error("table entry %0d not cleared", i);
    end
  end
endmodule

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = lvt_mpram_pkg::sel_width(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);
  logic [DW-1:0]    bank_q [NW][NR];
  logic [NR*LW-1:0] sel;

  lvt_table #(.NW(NW), .NR(NR), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_sel(sel)
  );

  genvar w, r;
  generate
    for (w = 0; w < NW; w++) begin : g_wr
      for (r = 0; r < NR; r++) begin : g_rd
        lvt_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
          .clk(clk), .we(wr_en[w]),
          .waddr(wr_addr[w*AW +: AW]), .wdata(wr_data[w*DW +: DW]),
          .raddr(rd_addr[r*AW +: AW]), .rdata(bank_q[w][r])
        );
        assert_bank_follow_R1: assert property (@(posedge clk) disable iff (rst)
          (wr_en[w] ##1 (rd_addr[r*AW +: AW] == $past(wr_addr[w*AW +: AW])))
          |=> bank_q[w][r] == $past(wr_data[w*DW +: DW], 2))
          else $error("bank %0d/%0d lost written data", w, r);
      end
    end
    for (r = 0; r < NR; r++) begin : g_mux
      always_comb begin
        rd_data[r*DW +: DW] = bank_q[0][r];
        for (int k = 1; k < NW; k++)
          if (sel[r*LW +: LW] == LW'(k)) rd_data[r*DW +: DW] = bank_q[k][r];
      end
    end
  endgenerate
endmodule

// File: tb/tb_lvt_mpram.sv
module tb_lvt_mpram;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2, NR = 2, DW = 32, DEPTH = 64, AW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  lvt_mpram #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  logic [DW-1:0] shadow [NW][DEPTH];
  bit            shv    [NW][DEPTH];
  int            owner  [DEPTH];
  logic [DW-1:0] pend   [NR];
  bit            pendv  [NR];

  logic [NW-1:0] d_we;
  logic [AW-1:0] d_wa [NW];
  logic [DW-1:0] d_wd [NW];
  logic [AW-1:0] d_ra [NR];

  task automatic tick();
    @(negedge clk);
    for (int r = 0; r < NR; r++) if (pendv[r]) begin
      checks++;
      if (rd_data[r*DW +: DW] !== pend[r]) begin
        errors++;
        $display("FAIL %s port %0d: got %h expected %h", tag, r, rd_data[r*DW +: DW], pend[r]);
      end
    end
    wr_en = d_we;
    for (int p = 0; p < NW; p++) begin
      wr_addr[p*AW +: AW] = d_wa[p];
      wr_data[p*DW +: DW] = d_wd[p];
    end
    for (int r = 0; r < NR; r++) begin
      rd_addr[r*AW +: AW] = d_ra[r];
      pendv[r] = !rst && shv[owner[d_ra[r]]][d_ra[r]];
      pend[r]  = shadow[owner[d_ra[r]]][d_ra[r]];
    end
    if (!rst) for (int p = 0; p < NW; p++) if (d_we[p]) begin
      shadow[p][d_wa[p]] = d_wd[p];
      shv[p][d_wa[p]] = 1'b1;
      owner[d_wa[p]] = p;
    end
  endtask

  task automatic idle();
    d_we = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle();
    tick(); tick();
    for (int i = 0; i < DEPTH; i++) owner[i] = 0;
    rst = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int p = 0; p < NW; p++) for (int i = 0; i < DEPTH; i++) shv[p][i] = 1'b0;
    for (int i = 0; i < DEPTH; i++) owner[i] = 0;
    for (int r = 0; r < NR; r++) begin pendv[r] = 0; d_ra[r] = '0; end
    for (int p = 0; p < NW; p++) begin d_wa[p] = '0; d_wd[p] = '0; end
    idle();
    do_reset();

    // R3 / R8: same-cycle example on separate lanes
    tag = "R3";
    d_we = 2'b11; d_wa[0] = 6'h12; d_wd[0] = 32'hAAAA0012; d_wa[1] = 6'h15; d_wd[1] = 32'hBBBB0015;
    tick(); idle();
    d_ra[0] = 6'h12; d_ra[1] = 6'h15; tick();
    tag = "R6"; d_ra[0] = 6'h15; d_ra[1] = 6'h15; tick();
    tag = "R1"; d_ra[0] = 6'h15; d_ra[1] = 6'h12; tick();

    // R2: override from the other port
    tag = "R2";
    d_we = 2'b01; d_wa[0] = 6'h15; d_wd[0] = 32'h0000C0DE; tick(); idle();
    d_ra[0] = 6'h15; d_ra[1] = 6'h12; tick(); tick();

    // R4: collisions
    tag = "R4";
    d_we = 2'b11; d_wa[0] = 6'h20; d_wd[0] = 32'h11111111; d_wa[1] = 6'h20; d_wd[1] = 32'h22222222;
    tick(); idle();
    d_ra[0] = 6'h20; d_ra[1] = 6'h20; tick();
    d_we = 2'b11; d_wa[0] = 6'h20; d_wd[0] = 32'h33333333; d_wa[1] = 6'h20; d_wd[1] = 32'h44444444;
    tick(); idle(); tick();

    // R5: read during write returns old value
    tag = "R5";
    d_we = 2'b10; d_wa[1] = 6'h12; d_wd[1] = 32'h55555555; d_ra[0] = 6'h12; d_ra[1] = 6'h12;
    tick(); idle(); tick(); tick();

    // R7: reset falls back to port 0 data
    tag = "R7";
    d_we = 2'b01; d_wa[0] = 6'h30; d_wd[0] = 32'h0A0A0A0A; tick();
    d_we = 2'b10; d_wa[1] = 6'h30; d_wd[1] = 32'h0B0B0B0B; tick(); idle();
    d_ra[0] = 6'h30; d_ra[1] = 6'h20; tick(); tick();
    do_reset();
    d_ra[0] = 6'h30; d_ra[1] = 6'h20; tick();
    d_ra[0] = 6'h12; d_ra[1] = 6'h15; tick(); tick();

    // random traffic over a narrow range
    tag = "R6";
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NW; p++) begin
        d_we[p] = $urandom_range(0, 1);
        d_wa[p] = AW'($urandom_range(0, 7));
        d_wd[p] = $urandom;
      end
      for (int r = 0; r < NR; r++) d_ra[r] = AW'($urandom_range(0, 7));
      tick();
    end
    idle(); tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule